// File: doc/BRIEF.md
# Masked Vector Move Execution Unit

This unit is one registered pipeline stage that carries out aligned packed-integer vector moves into a 512-bit destination register. Each request supplies a source vector, the current destination value, a 16-bit element writemask and a set of control fields. The control fields are the vector length, the element size, the encoding class, the masking mode, the instruction form (register copy, load or store), the memory address and the 4-bit reserved operand-specifier field.

One clock after a valid request the unit returns one of two results. For register-copy and load forms it returns the new destination value and a register write strobe. For the store form it returns store data together with a 64-bit per-byte write enable. It also raises a general-protection flag for a misaligned memory operand and an undefined-opcode flag for a bad reserved field or an illegal code. A raised fault suppresses every write.

The field codes are as follows. The vector length `vlenSel` is 0 for 128 bits, 1 for 256 bits, and 2 or 3 for 512 bits. The encoding class `encClass` is 0 for legacy, 1 for VEX, 2 for EVEX and 3 for reserved. The form `opForm` is 0 for register copy, 1 for load, 2 for store and 3 for reserved. The element size `elemWide` is 0 for 32-bit elements and 1 for 64-bit elements. The masking mode `zeroMask` is 0 for merge and 1 for zero.

Top module: `vec_move_unit`

## Requirements
- R1: `rspValid` is high exactly one clock after a cycle with `reqValid` high. After a cycle with `reqValid` low, `rspValid`, `dstWrite`, `storeByteEn` and both fault flags are 0, and `newDst` holds its previous value.
- R2: With EVEX encoding, element j is copied from `srcVec` when `writeMask[j]` is 1. An element covers bits 32j+31:32j when `elemWide`=0 and bits 64j+63:64j when `elemWide`=1. Mask bits at or above the element count (vector length divided by element size) have no effect.
- R3: With EVEX encoding in the register-copy and load forms, an in-length element whose mask bit is 0 keeps its `oldDst` value when `zeroMask`=0 and becomes zero when `zeroMask`=1.
- R4: Legacy and VEX encodings ignore `writeMask` and `zeroMask`, so every element below the vector length is copied from `srcVec`.
- R5: With VEX or EVEX encoding in the register-copy and load forms, `newDst` bits from the vector length up to bit 511 are zero.
- R6: Legacy encoding always works on 128 bits whatever the value of `vlenSel`. In the register-copy and load forms, `newDst[511:128]` equals `oldDst[511:128]`.
- R7: The store form never asserts `dstWrite`. `storeByteEn[b]` is 1 exactly when byte b lies below the vector length and its element is copied. `newDst` carries the `srcVec` bytes at the enabled positions and zero elsewhere. `zeroMask` has no effect on the store form.
- R8: A load or store whose `memAddr` is not a multiple of 16, 32 or 64 bytes (for 128, 256 or 512 bits) sets `gpFault`. The register-copy form never sets `gpFault`.
- R9: `udFault` is set when the encoding is VEX or EVEX and `resField` is not 4'b1111, when `encClass`=3, or when `opForm`=3. A legacy encoding with a legal form never sets it.
- R10: When either fault flag is set in a response, `dstWrite` is 0, `storeByteEn` is all zero and `newDst` equals the `oldDst` of that request.
- R11: While `rstN` is low, `rspValid`, `dstWrite`, `storeByteEn`, `newDst`, `gpFault` and `udFault` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| srcVec | input | 512 | Source vector |
| oldDst | input | 512 | Current destination register value |
| writeMask | input | 16 | Per-element writemask |
| vlenSel | input | 2 | Vector length code |
| elemWide | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| encClass | input | 2 | Encoding class code |
| zeroMask | input | 1 | 0: merge masking, 1: zero masking |
| opForm | input | 2 | Form code |
| memAddr | input | ADDR_W | Memory operand byte address |
| resField | input | 4 | Reserved operand-specifier field |
| rspValid | output | 1 | Response valid |
| newDst | output | 512 | New destination value or store data |
| dstWrite | output | 1 | Destination register write strobe |
| storeByteEn | output | 64 | Per-byte store enable |
| gpFault | output | 1 | General-protection fault |
| udFault | output | 1 | Undefined-opcode fault |

## Verification
All state in this unit is the single response register, so a wrong lane strobe shows up in the next cycle's response. It appears as a wrong 32-bit lane of `newDst`, a missing or extra group of four `storeByteEn` bits, or a write strobe that escapes a fault. A wrong decode of vector length or encoding shows as upper lanes that are kept when they should be cleared, or cleared when they should be kept. The bench feeds directed corner cases and then mixed random requests into a behavioural byte-by-byte model, and compares every output on every clock, so such an error is reported in the cycle where it first appears.

// File: rtl/vmove_pkg.sv
package vmove_pkg;
  parameter int VEC_W      = 512;
  parameter int LANE_W     = 32;
  parameter int NUM_LANES  = VEC_W / LANE_W;
  parameter int LANE_BYTES = LANE_W / 8;
  parameter int VEC_BYTES  = VEC_W / 8;
  parameter int MASK_W     = 16;

  typedef enum logic [1:0] {ENC_LEGACY = 2'd0, ENC_VEX = 2'd1, ENC_EVEX = 2'd2, ENC_RSVD = 2'd3} encClass_e;
  typedef enum logic [1:0] {FORM_REG = 2'd0, FORM_LOAD = 2'd1, FORM_STORE = 2'd2, FORM_RSVD = 2'd3} form_e;

  typedef struct packed {
    logic [NUM_LANES-1:0] laneCopy;
    logic [NUM_LANES-1:0] laneClear;
    logic                 regWrite;
    logic                 storeWrite;
    logic                 gpFault;
    logic                 udFault;
  } strobes_t;
endpackage

// File: rtl/vmove_ctrl.sv
module vmove_ctrl
  import vmove_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MASK_W-1:0] writeMask,
  input  logic [1:0]        vlenSel,
  input  logic              elemWide,
  input  logic [1:0]        encClass,
  input  logic              zeroMask,
  input  logic [1:0]        opForm,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [3:0]        resField,
  output strobes_t          stb
);
  localparam int CNT_W = $clog2(NUM_LANES) + 1;

  logic                 isLegacy, isEvex, isMem, isStore, anyFault;
  logic [CNT_W-1:0]     vlLanes;
  logic [5:0]           alignMask;
  logic [NUM_LANES-1:0] inLen, selLane, copyRaw;

  always_comb begin
    isLegacy = (encClass == ENC_LEGACY);
    isEvex   = (encClass == ENC_EVEX);
    isStore  = (opForm == FORM_STORE);
    isMem    = (opForm == FORM_LOAD) || isStore;
    if (isLegacy || vlenSel == 2'd0) begin
      vlLanes   = CNT_W'(NUM_LANES / 4);
      alignMask = 6'h0F;
    end else if (vlenSel == 2'd1) begin
      vlLanes   = CNT_W'(NUM_LANES / 2);
      alignMask = 6'h1F;
    end else begin
      vlLanes   = CNT_W'(NUM_LANES);
      alignMask = 6'h3F;
    end
  end

  for (genvar c = 0; c < NUM_LANES; c++) begin : g_lane
    logic maskBit;
    assign maskBit    = elemWide ? writeMask[c/2] : writeMask[c];
    assign inLen[c]   = (CNT_W'(c) < vlLanes);
    assign selLane[c] = !isEvex || maskBit;
    assign copyRaw[c] = inLen[c] && selLane[c];
  end

  always_comb begin
    stb.gpFault = isMem && ((memAddr[5:0] & alignMask) != 6'd0);
    stb.udFault = (encClass == ENC_RSVD) || (opForm == FORM_RSVD) ||
                  (!isLegacy && resField != 4'hF);
    anyFault    = stb.gpFault || stb.udFault;
    stb.regWrite   = !anyFault && !isStore;
    stb.storeWrite = !anyFault && isStore;
    if (anyFault) begin
      stb.laneCopy  = '0;
      stb.laneClear = '0;
    end else if (isStore) begin
      stb.laneCopy  = copyRaw;
      stb.laneClear = ~copyRaw;
    end else begin
      stb.laneCopy  = copyRaw;
      stb.laneClear = (inLen & ~selLane & {NUM_LANES{isEvex && zeroMask}}) |
                      (~inLen & {NUM_LANES{!isLegacy}});
    end
  end

  assert_fault_no_lane_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.gpFault || stb.udFault) |-> (stb.laneCopy == '0 && stb.laneClear == '0 &&
                                      !stb.regWrite && !stb.storeWrite));

  assert_copy_clear_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.laneCopy & stb.laneClear) == '0);

  assert_legacy_no_ud_R9: assert property (@(posedge clk) disable iff (!rstN)
    (encClass == ENC_LEGACY && opForm != FORM_RSVD) |-> !stb.udFault);

  assert_reg_no_gp_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opForm == FORM_REG) |-> !stb.gpFault);

  for (genvar p = 0; p < NUM_LANES / 2; p++) begin : g_pair
    assert_wide_pairs_R2: assert property (@(posedge clk) disable iff (!rstN)
      (elemWide && isEvex) |-> (stb.laneCopy[2*p] == stb.laneCopy[2*p+1]));
  end
endmodule

// File: rtl/vmove_datapath.sv
module vmove_datapath
  import vmove_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [VEC_W-1:0]     srcVec,
  input  logic [VEC_W-1:0]     oldDst,
  input  strobes_t             stb,
  output logic                 rspValid,
  output logic [VEC_W-1:0]     newDst,
  output logic                 dstWrite,
  output logic [VEC_BYTES-1:0] storeByteEn,
  output logic                 gpFault,
  output logic                 udFault
);
  logic [VEC_W-1:0]     dstNext;
  logic [VEC_BYTES-1:0] byteEnNext;

  for (genvar c = 0; c < NUM_LANES; c++) begin : g_lane
    assign dstNext[c*LANE_W +: LANE_W] =
      stb.laneCopy[c]  ? srcVec[c*LANE_W +: LANE_W] :
      stb.laneClear[c] ? '0 : oldDst[c*LANE_W +: LANE_W];
    assign byteEnNext[c*LANE_BYTES +: LANE_BYTES] =
      {LANE_BYTES{stb.storeWrite && stb.laneCopy[c]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      newDst      <= '0;
      dstWrite    <= 1'b0;
      storeByteEn <= '0;
      gpFault     <= 1'b0;
      udFault     <= 1'b0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        newDst      <= dstNext;
        dstWrite    <= stb.regWrite;
        storeByteEn <= byteEnNext;
        gpFault     <= stb.gpFault;
        udFault     <= stb.udFault;
      end else begin
        dstWrite    <= 1'b0;
        storeByteEn <= '0;
        gpFault     <= 1'b0;
        udFault     <= 1'b0;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !dstWrite && storeByteEn == '0 && $stable(newDst)));

  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (stb.gpFault || stb.udFault)) |=>
      (!dstWrite && storeByteEn == '0 && newDst == $past(oldDst)));

  assert_store_no_reg_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(dstWrite && storeByteEn != '0));
endmodule

// File: rtl/vec_move_unit.sv
module vec_move_unit
  import vmove_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [VEC_W-1:0]     srcVec,
  input  logic [VEC_W-1:0]     oldDst,
  input  logic [MASK_W-1:0]    writeMask,
  input  logic [1:0]           vlenSel,
  input  logic                 elemWide,
  input  logic [1:0]           encClass,
  input  logic                 zeroMask,
  input  logic [1:0]           opForm,
  input  logic [ADDR_W-1:0]    memAddr,
  input  logic [3:0]           resField,
  output logic                 rspValid,
  output logic [VEC_W-1:0]     newDst,
  output logic                 dstWrite,
  output logic [VEC_BYTES-1:0] storeByteEn,
  output logic                 gpFault,
  output logic                 udFault
);
  strobes_t stb;

  vmove_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .writeMask(writeMask), .vlenSel(vlenSel),
    .elemWide(elemWide), .encClass(encClass), .zeroMask(zeroMask),
    .opForm(opForm), .memAddr(memAddr), .resField(resField), .stb(stb)
  );

  vmove_datapath u_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .srcVec(srcVec),
    .oldDst(oldDst), .stb(stb), .rspValid(rspValid), .newDst(newDst),
    .dstWrite(dstWrite), .storeByteEn(storeByteEn), .gpFault(gpFault),
    .udFault(udFault)
  );
endmodule

// File: tb/sim_vec_move_unit.sv
module sim_vec_move_unit;
  localparam int ADDR_W = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [511:0] srcVec = '0, oldDst = '0;
  logic [15:0] writeMask = '0;
  logic [1:0] vlenSel = '0, encClass = '0, opForm = '0;
  logic elemWide = 1'b0, zeroMask = 1'b0;
  logic [ADDR_W-1:0] memAddr = '0;
  logic [3:0] resField = 4'hF;
  logic rspValid, dstWrite, gpFault, udFault;
  logic [511:0] newDst;
  logic [63:0] storeByteEn;

  logic expValid = 1'b0, expWr = 1'b0, expGp = 1'b0, expUd = 1'b0;
  logic [511:0] expDst = '0;
  logic [63:0] expBe = '0;
  string curTag = "R11";
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  vec_move_unit #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .srcVec(srcVec), .oldDst(oldDst),
    .writeMask(writeMask), .vlenSel(vlenSel), .elemWide(elemWide), .encClass(encClass),
    .zeroMask(zeroMask), .opForm(opForm), .memAddr(memAddr), .resField(resField),
    .rspValid(rspValid), .newDst(newDst), .dstWrite(dstWrite), .storeByteEn(storeByteEn),
    .gpFault(gpFault), .udFault(udFault)
  );

  task automatic compareOut();
    checks++;
    if (rspValid !== expValid || dstWrite !== expWr || gpFault !== expGp ||
        udFault !== expUd || storeByteEn !== expBe || newDst !== expDst) begin
      errors++;
      $display("FAIL %s: got v=%0b wr=%0b gp=%0b ud=%0b be=%h dst=%h exp v=%0b wr=%0b gp=%0b ud=%0b be=%h dst=%h",
               curTag, rspValid, dstWrite, gpFault, udFault, storeByteEn, newDst,
               expValid, expWr, expGp, expUd, expBe, expDst);
    end
  endtask

  task automatic computeExp();
    int lenBits;
    int eBytes;
    logic en;
    if (!reqValid) begin
      expValid = 0; expWr = 0; expBe = '0; expGp = 0; expUd = 0;
      return;
    end
    lenBits = (encClass == 2'd0 || vlenSel == 2'd0) ? 128 : (vlenSel == 2'd1 ? 256 : 512);
    eBytes = elemWide ? 8 : 4;
    expValid = 1;
    expUd = (encClass == 2'd3) || (opForm == 2'd3) || (encClass != 2'd0 && resField != 4'hF);
    expGp = (opForm == 2'd1 || opForm == 2'd2) &&
            ((memAddr & ADDR_W'(lenBits / 8 - 1)) != '0);
    if (expGp || expUd) begin
      expDst = oldDst; expWr = 0; expBe = '0;
    end else if (opForm == 2'd2) begin
      expWr = 0; expDst = '0; expBe = '0;
      for (int b = 0; b < lenBits / 8; b++) begin
        en = (encClass != 2'd2) || writeMask[b / eBytes];
        if (en) begin
          expDst[b*8 +: 8] = srcVec[b*8 +: 8];
          expBe[b] = 1'b1;
        end
      end
    end else begin
      expWr = 1; expBe = '0;
      expDst = (encClass == 2'd0) ? oldDst : '0;
      for (int b = 0; b < lenBits / 8; b++) begin
        en = (encClass != 2'd2) || writeMask[b / eBytes];
        if (en) expDst[b*8 +: 8] = srcVec[b*8 +: 8];
        else if (zeroMask) expDst[b*8 +: 8] = 8'h00;
        else expDst[b*8 +: 8] = oldDst[b*8 +: 8];
      end
    end
  endtask

  task automatic step(input logic v, input logic [1:0] enc, input logic [1:0] form,
                      input logic [1:0] vl, input logic wide, input logic zm,
                      input logic [15:0] msk, input logic [ADDR_W-1:0] addr,
                      input logic [3:0] res, input string tag);
    @(negedge clk);
    compareOut();
    reqValid = v; encClass = enc; opForm = form; vlenSel = vl; elemWide = wide;
    zeroMask = zm; writeMask = msk; memAddr = addr; resField = res;
    for (int i = 0; i < 16; i++) begin
      srcVec[i*32 +: 32] = $urandom;
      oldDst[i*32 +: 32] = $urandom;
    end
    computeExp();
    curTag = tag;
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    curTag = "R11";
    compareOut();
    rstN = 1'b1;
    // R2: EVEX 512-bit, 32-bit elements, merge
    step(1, 2'd2, 2'd0, 2'd2, 0, 0, 16'hA5A5, '0, 4'hF, "R2");
    // R3: same with zero masking; then merge load
    step(1, 2'd2, 2'd1, 2'd2, 0, 1, 16'h3C0F, 48'h40, 4'hF, "R3");
    step(1, 2'd2, 2'd1, 2'd2, 1, 0, 16'h0052, 48'h80, 4'hF, "R3");
    // R2: 64-bit elements, mask bits 8..15 ignored
    step(1, 2'd2, 2'd0, 2'd2, 1, 1, 16'hFF35, '0, 4'hF, "R2");
    // R5: EVEX 256 zero-masking load, upper cleared
    step(1, 2'd2, 2'd1, 2'd1, 0, 1, 16'hFF6B, 48'h20, 4'hF, "R5");
    // R4 and R5: VEX ignores mask
    step(1, 2'd1, 2'd0, 2'd0, 0, 1, 16'h0000, '0, 4'hF, "R4");
    step(1, 2'd1, 2'd1, 2'd1, 1, 1, 16'h0001, 48'h1E0, 4'hF, "R4");
    // R6: legacy ignores vlenSel, keeps upper
    step(1, 2'd0, 2'd1, 2'd2, 0, 1, 16'h0000, 48'h30, 4'h0, "R6");
    step(1, 2'd0, 2'd0, 2'd1, 1, 0, 16'h0003, '0, 4'h5, "R6");
    // R7: stores
    step(1, 2'd2, 2'd2, 2'd2, 0, 1, 16'h0F0F, 48'h100, 4'hF, "R7");
    step(1, 2'd1, 2'd2, 2'd1, 0, 0, 16'h0000, 48'h20, 4'hF, "R7");
    step(1, 2'd2, 2'd2, 2'd0, 1, 0, 16'hFFFE, 48'h10, 4'hF, "R7");
    // R8: alignment
    step(1, 2'd2, 2'd1, 2'd2, 0, 0, 16'hFFFF, 48'h20, 4'hF, "R8");
    step(1, 2'd2, 2'd0, 2'd2, 0, 0, 16'hFFFF, 48'h3, 4'hF, "R8");
    step(1, 2'd1, 2'd1, 2'd0, 0, 0, 16'hFFFF, 48'h10, 4'hF, "R8");
    step(1, 2'd1, 2'd1, 2'd1, 0, 0, 16'hFFFF, 48'h10, 4'hF, "R8");
    // R9: undefined-opcode cases
    step(1, 2'd1, 2'd0, 2'd0, 0, 0, 16'h0000, '0, 4'hE, "R9");
    step(1, 2'd0, 2'd0, 2'd0, 0, 0, 16'h0000, '0, 4'h0, "R9");
    step(1, 2'd3, 2'd0, 2'd0, 0, 0, 16'h0000, '0, 4'hF, "R9");
    step(1, 2'd2, 2'd3, 2'd0, 0, 0, 16'h0000, '0, 4'hF, "R9");
    // R10: faulting store writes nothing
    step(1, 2'd2, 2'd2, 2'd2, 0, 0, 16'hFFFF, 48'h8, 4'hF, "R10");
    step(1, 2'd2, 2'd2, 2'd2, 0, 0, 16'hFFFF, 48'h0, 4'h7, "R10");
    // R1: idle cycles hold newDst
    step(0, 2'd2, 2'd0, 2'd2, 0, 0, 16'hFFFF, '0, 4'hF, "R1");
    step(0, 2'd2, 2'd0, 2'd2, 0, 0, 16'hFFFF, '0, 4'hF, "R1");
    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] a;
      logic [3:0] r;
      a = ADDR_W'($urandom);
      if ($urandom % 4 != 0) a[5:0] = 6'd0;
      r = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
      step(($urandom % 10) != 0, 2'($urandom % 3), 2'($urandom % 3), 2'($urandom),
           1'($urandom), 1'($urandom), 16'($urandom), a, r, "R2");
    end
    step(0, 2'd0, 2'd0, 2'd0, 0, 0, 16'h0, '0, 4'hF, "R1");
    @(negedge clk);
    compareOut();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule